// File: doc/BRIEF.md
# PHY management command register

This block gives software a single 32-bit command word for reaching the registers of an attached PHY. Software writes the word with a register index, a 16-bit data value, read and write flags and a start/busy flag. If start/busy is set, the block makes one access on a plain register port toward the PHY. When that access is done, the block clears busy by itself, merges read data into the data field of the same word, and posts a sticky done status bit. Software then reads the command word back to get the result.

Three host-visible registers are selected by a 2-bit select: the command word (0), the done status (1, bit 0) and the interrupt mask (2, bit 0). Select 3 reads as zero. The host port is a one-cycle write strobe with a combinational read-back. Serial pin timing and PHY address decoding are not handled here; the PHY address field is only stored.

Top module: `mgmt_cmd_engine`

## Requirements
- R1: Command word layout: data in bits [15:0], register index in [20:16], PHY address in [25:21], write flag bit 26, read flag bit 27, start/busy bit 29. Bits 28, 30 and 31 always read back as zero.
- R2: A command write with bit 29 clear is stored as written (reserved bits dropped) and makes no PHY request.
- R3: A command write with bit 29 set keeps busy readable as 1 during the request cycle and the following cycle. Busy reads 0 from the second cycle after the write edge onward.
- R4: With the read flag set, the PHY value returned the cycle after the request replaces bits [15:0] of the stored word.
- R5: With the write flag set and the read flag clear, one PHY write is made to the given index with the stored data.
- R6: When read and write flags are both set, a read is made and no PHY write occurs.
- R7: The done status bit is set when a command completes. This is at the write edge for a non-start word and at busy clear for a started word.
- R8: Writing 1 to status bit 0 clears done. Writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R9: irq_o is high exactly when done status and mask bit 0 are both 1.
- R10: Command writes that arrive while busy is set are ignored.
- R11: Reset clears the command word, the done status and the mask.
- R12: A started command makes at most one PHY request, and only when the read or write flag is set. The request comes in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe, one cycle |
| host_sel_i | input | 2 | Register select: 0 command, 1 status, 2 mask |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Management-done interrupt |
| phy_req_o | output | 1 | PHY register access request, one cycle |
| phy_we_o | output | 1 | Access is a write |
| phy_idx_o | output | 5 | PHY register index |
| phy_wdata_o | output | 16 | PHY write data |
| phy_rdata_i | input | 16 | PHY read data, valid the cycle after the request |

## Verification
A stuck sequencer shows up at the ports as a busy bit that is still 1 in the read-back two cycles after the write edge. A sequencer that skips a state shows busy cleared too early. A wrong merge shows as a data field that does not match what the PHY model returned, and it is visible at the first read-back after completion. A wrong read/write priority or a duplicated request shows on the PHY port in the cycle after the write edge, and it also corrupts a later read of the same PHY register. Errors in the status or mask logic show on irq_o in the cycle after the write that caused them.

// File: rtl/mgmt_cmd_pkg.sv
package mgmt_cmd_pkg;
  localparam int WORD_W    = 32;
  localparam int DATA_W    = 16;
  localparam int IDX_LSB   = 16;
  localparam int IDX_W     = 5;
  localparam int PADDR_LSB = 21;
  localparam int PADDR_W   = 5;
  localparam int WR_BIT    = 26;
  localparam int RD_BIT    = 27;
  localparam int BUSY_BIT  = 29;
  localparam int SEL_W     = 2;

  // defined bits of the command word: [27:0] and busy
  localparam logic [WORD_W-1:0] CMD_KEEP =
    ((WORD_W'(1) << (RD_BIT + 1)) - WORD_W'(1)) | (WORD_W'(1) << BUSY_BIT);

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ISSUE, SEQ_WAIT} seq_e;

  localparam logic [SEL_W-1:0] SEL_CMD  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MASK = 2'd2;
endpackage

// File: rtl/mgmt_cmd_seq.sv
module mgmt_cmd_seq
  import mgmt_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [WORD_W-1:0] cmd_wdata_i,
  input  logic [DATA_W-1:0] phy_rdata_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic              done_o,
  output logic              phy_req_o,
  output logic              phy_we_o,
  output logic [IDX_W-1:0]  phy_idx_o,
  output logic [DATA_W-1:0] phy_wdata_o
);
  seq_e              st_q;
  logic [WORD_W-1:0] cmd_q;
  logic              rd_f, wr_f;

  assign rd_f = cmd_q[RD_BIT];
  assign wr_f = cmd_q[WR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      cmd_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (cmd_we_i) begin
          cmd_q <= cmd_wdata_i & CMD_KEEP;
          if (cmd_wdata_i[BUSY_BIT]) st_q <= SEQ_ISSUE;
        end
        SEQ_ISSUE: st_q <= SEQ_WAIT;
        SEQ_WAIT: begin
          cmd_q[BUSY_BIT] <= 1'b0;
          if (rd_f) cmd_q[DATA_W-1:0] <= phy_rdata_i;
          st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign cmd_o       = cmd_q;
  assign done_o      = (st_q == SEQ_WAIT) ||
                       (st_q == SEQ_IDLE && cmd_we_i && !cmd_wdata_i[BUSY_BIT]);
  assign phy_req_o   = (st_q == SEQ_ISSUE) && (rd_f || wr_f);
  assign phy_we_o    = (st_q == SEQ_ISSUE) && wr_f && !rd_f;
  assign phy_idx_o   = cmd_q[IDX_LSB +: IDX_W];
  assign phy_wdata_o = cmd_q[DATA_W-1:0];

  a_r3_busy_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != SEQ_IDLE) |-> cmd_q[BUSY_BIT]);
  a_r3_busy_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_WAIT) |=> !cmd_q[BUSY_BIT]);
  a_r4_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_WAIT && rd_f) |=> (cmd_q[DATA_W-1:0] == $past(phy_rdata_i)));
  a_r6_read_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && rd_f) |-> !phy_we_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_ISSUE) |=> $stable(cmd_q));
  a_r12_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |=> !phy_req_o);
endmodule

// File: rtl/mgmt_irq_stat.sv
module mgmt_irq_stat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_set_i,
  input  logic stat_we_i,
  input  logic stat_wbit_i,
  input  logic mask_we_i,
  input  logic mask_wbit_i,
  output logic done_o,
  output logic mask_o,
  output logic irq_o
);
  logic done_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (done_set_i)                    done_q <= 1'b1;
      else if (stat_we_i && stat_wbit_i) done_q <= 1'b0;
      if (mask_we_i) mask_q <= mask_wbit_i;
    end
  end

  assign done_o = done_q;
  assign mask_o = mask_q;
  assign irq_o  = done_q & mask_q;

  a_r7_done_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_i |=> done_o);
  a_r8_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && stat_wbit_i && !done_set_i) |=> !done_o);
  a_r8_w0_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(stat_we_i && stat_wbit_i)) |=> done_o);
endmodule

// File: rtl/mgmt_cmd_engine.sv
module mgmt_cmd_engine
  import mgmt_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [SEL_W-1:0]  host_sel_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic              irq_o,
  output logic              phy_req_o,
  output logic              phy_we_o,
  output logic [IDX_W-1:0]  phy_idx_o,
  output logic [DATA_W-1:0] phy_wdata_o,
  input  logic [DATA_W-1:0] phy_rdata_i
);
  logic [WORD_W-1:0] cmd;
  logic done_pulse, done_st, mask_st;
  logic cmd_we, stat_we, mask_we;

  assign cmd_we  = host_wr_i && (host_sel_i == SEL_CMD);
  assign stat_we = host_wr_i && (host_sel_i == SEL_STAT);
  assign mask_we = host_wr_i && (host_sel_i == SEL_MASK);

  mgmt_cmd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we),
    .cmd_wdata_i (host_wdata_i),
    .phy_rdata_i (phy_rdata_i),
    .cmd_o       (cmd),
    .done_o      (done_pulse),
    .phy_req_o   (phy_req_o),
    .phy_we_o    (phy_we_o),
    .phy_idx_o   (phy_idx_o),
    .phy_wdata_o (phy_wdata_o)
  );

  mgmt_irq_stat u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_set_i  (done_pulse),
    .stat_we_i   (stat_we),
    .stat_wbit_i (host_wdata_i[0]),
    .mask_we_i   (mask_we),
    .mask_wbit_i (host_wdata_i[0]),
    .done_o      (done_st),
    .mask_o      (mask_st),
    .irq_o       (irq_o)
  );

  always_comb begin
    unique case (host_sel_i)
      SEL_CMD:  host_rdata_o = cmd;
      SEL_STAT: host_rdata_o = {{(WORD_W-1){1'b0}}, done_st};
      SEL_MASK: host_rdata_o = {{(WORD_W-1){1'b0}}, mask_st};
      default:  host_rdata_o = '0;
    endcase
  end

  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (u_irq.mask_o && u_irq.done_o));
  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd & ~CMD_KEEP) == '0);
endmodule

// File: tb/sim_mgmt_cmd_engine.sv
`timescale 1ns/1ps
module sim_mgmt_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq, phy_req, phy_we;
  logic [4:0]  phy_idx;
  logic [15:0] phy_wdata, phy_rdata;
  logic [15:0] mem [32];
  int n_chk = 0, n_bad = 0, req_cnt = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  mgmt_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_sel_i(host_sel),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .irq_o(irq),
    .phy_req_o(phy_req), .phy_we_o(phy_we), .phy_idx_o(phy_idx),
    .phy_wdata_o(phy_wdata), .phy_rdata_i(phy_rdata)
  );

  // PHY register model: read data registered one cycle after request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= 16'hA500 + 16'(i);
      phy_rdata <= '0;
    end else if (phy_req) begin
      phy_rdata <= mem[phy_idx];
      if (phy_we) mem[phy_idx] <= phy_wdata;
    end
  end

  always @(posedge clk) if (rst_n && phy_req) req_cnt++;

  typedef struct packed {
    logic [31:0] word;
    logic [31:0] rb;
    logic        req;
    logic        we;
  } vec_t;

  // R1 R2 R4 R5 R6 R12 vectors; PHY model starts with mem[i] = A500+i
  localparam vec_t VECS [10] = '{
    '{32'h2403_1234, 32'h0403_1234, 1'b1, 1'b1},  // R5 write idx 3
    '{32'h2803_0000, 32'h0803_1234, 1'b1, 1'b0},  // R4 read idx 3
    '{32'h2C07_FFFF, 32'h0C07_A507, 1'b1, 1'b0},  // R6 both flags
    '{32'h2807_0000, 32'h0807_A507, 1'b1, 1'b0},  // R6 no write happened
    '{32'h0405_5555, 32'h0405_5555, 1'b0, 1'b0},  // R2 start clear
    '{32'h2805_0000, 32'h0805_A505, 1'b1, 1'b0},  // R2 idx 5 untouched
    '{32'hF000_0000, 32'h0000_0000, 1'b0, 1'b0},  // R1 R12 no flags
    '{32'h2BE1_0000, 32'h0BE1_A501, 1'b1, 1'b0},  // R1 PHY address kept
    '{32'h241F_BEEF, 32'h041F_BEEF, 1'b1, 1'b1},  // R5 top index
    '{32'h281F_0000, 32'h081F_BEEF, 1'b1, 1'b0}   // R4 top index
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    host_sel = sel;
    #1 d = host_rdata;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    rd(2'd0, d); chk("R11 cmd after reset", d, 32'h0);
    rd(2'd1, d); chk("R11 status after reset", d, 32'h0);
    rd(2'd2, d); chk("R11 mask after reset", d, 32'h0);
    chk("R11 irq after reset", {31'b0, irq}, 32'h0);

    foreach (VECS[k]) begin
      c0 = req_cnt;
      host_write(2'd0, VECS[k].word);
      chk($sformatf("R12 req vec %0d", k), {31'b0, phy_req}, {31'b0, VECS[k].req});
      if (VECS[k].req) begin
        chk($sformatf("R5 R6 we vec %0d", k), {31'b0, phy_we}, {31'b0, VECS[k].we});
        chk($sformatf("R5 idx vec %0d", k), {27'b0, phy_idx}, {27'b0, VECS[k].word[20:16]});
      end
      repeat (2) @(negedge clk);
      rd(2'd0, d); chk($sformatf("R1 R4 readback vec %0d", k), d, VECS[k].rb);
      chk($sformatf("R12 req count vec %0d", k), 32'(req_cnt - c0), {31'b0, VECS[k].req});
      rd(2'd1, d); chk($sformatf("R7 done vec %0d", k), d, 32'h1);
      host_write(2'd1, 32'h1);
      rd(2'd1, d); chk($sformatf("R8 clear vec %0d", k), d, 32'h0);
    end

    // R3 busy visible for two cycles, then clear
    host_write(2'd0, 32'h2803_0000);
    rd(2'd0, d); chk("R3 busy request cycle", {31'b0, d[29]}, 32'h1);
    rd(2'd1, d); chk("R7 no done while busy", d, 32'h0);
    @(negedge clk);
    rd(2'd0, d); chk("R3 busy wait cycle", {31'b0, d[29]}, 32'h1);
    @(negedge clk);
    rd(2'd0, d); chk("R3 busy cleared", {31'b0, d[29]}, 32'h0);

    // R10 write while busy ignored
    host_write(2'd1, 32'h1);
    c0 = req_cnt;
    host_write(2'd0, 32'h2803_0000);
    host_wr = 1'b1; host_sel = 2'd0; host_wdata = 32'h2405_0BAD;
    repeat (2) @(negedge clk);
    host_wr = 1'b0;
    rd(2'd0, d); chk("R10 busy write ignored", d, 32'h0803_1234);
    chk("R10 no extra request", 32'(req_cnt - c0), 32'h1);
    host_write(2'd0, 32'h2805_0000);
    repeat (2) @(negedge clk);
    rd(2'd0, d); chk("R10 idx 5 not written", d, 32'h0805_A505);

    // R8 write 0 keeps, R9 irq gating
    rd(2'd1, d); chk("R7 done before w0", d, 32'h1);
    host_write(2'd1, 32'h0);
    rd(2'd1, d); chk("R8 write 0 keeps", d, 32'h1);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    host_write(2'd2, 32'h1);
    chk("R9 irq enabled", {31'b0, irq}, 32'h1);
    host_write(2'd1, 32'h1);
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);
    host_write(2'd0, 32'h0000_0042);
    chk("R9 irq on non-start write", {31'b0, irq}, 32'h1);
    rd(2'd3, d); chk("R1 unused select zero", d, 32'h0);

    // R11 reset mid-run
    host_write(2'd0, 32'h2403_7777);
    rst_n = 1'b0;
    #1;
    rd(2'd0, d); chk("R11 cmd cleared", d, 32'h0);
    rd(2'd1, d); chk("R11 status cleared", d, 32'h0);
    rd(2'd2, d); chk("R11 mask cleared", d, 32'h0);
    chk("R11 irq low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule